// File: doc/BRIEF.md
# Link Authentication Status and Interrupt Unit

This block keeps the host-visible state of a video link transmitter's content-protection handshake with a downstream receiver. It provides two eight-bit registers on a simple register bus. One is a read-only status register. The other is a read/write interrupt control register. The block also drives one interrupt line to the host controller. Its inputs are single-cycle events and steady levels from the link and authentication logic, plus the write pulses the host uses to hand key material back to the engine.

The status bits clear in different ways. Some are sticky and clear when the status register is read. Some are held until the host confirms a key through a handshake write. The authenticated bit follows the state of the link. The rest mirror live inputs. Each interrupt source has its own enable bit, and a global enable gates all of them. The receiver-detect source can be configured to wait until the downstream receiver also reports lock.

Top module: `lnk_auth_irq`

## Requirements
- R1: After reset, the sticky bits, the held bits, the pass/fail/access flags and the whole control register are 0. With all level inputs low, reads at 0xC4 and 0xC6 return 0x00 and `irq` is 0.
- R2: The status register is read at 0xC4. Its bits 7 to 0 are: channel error, downstream interrupt, downstream lock, downstream hot-plug, receiver present, key list ready, receiver key ready, authenticated. Bits 6, 5 and 3 show `dsirq_n`, `ds_lock` and `rx_present` as they are, so bit 6 = 0 means a downstream interrupt is pending.
- R3: The channel-error bit (7) and the hot-plug bit (4) are set by their event pulses. They stay set until a read strobe at 0xC4, and are 0 from the next cycle after that read.
- R4: If a set event and its clearing action fall in the same cycle, the bit is 1 in the next cycle.
- R5: Key-list-ready (bit 2) is set by its event and cleared only by a `wr_list_valid` pulse. Key-ready (bit 1) is set by its event and cleared only by a `wr_key_valid` pulse.
- R6: Authenticated (bit 0) is set by `ev_auth_pass`. It is cleared by `ev_auth_fail` or `ev_auth_restart`.
- R7: The control register at 0xC6 stores written data and reads it back. Its bits 7 to 0 enable: indirect-access complete, receiver detect, downstream interrupt, list ready, key ready, authentication failure/loss, authentication pass, global.
- R8: `irq` = bit 0 AND (OR of each enabled pending source). Pass, fail and indirect-access-complete are recorded in internal sticky flags that clear on a status read. The downstream-interrupt source is `dsirq_n` = 0. The list-ready and key-ready sources are status bits 2 and 1.
- R9: The receiver-detect source is `rx_present`. When `rxdet_sel` = 1, it is pending only while `ds_lock` is also 1.
- R10: Writes to 0xC4 change nothing. Reads at any other address than 0xC4/0xC6 return 0x00 and clear no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives clear-on-read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ev_chan_err | input | 1 | Control-channel error event |
| dsirq_n | input | 1 | Downstream interrupt level, active low |
| ds_lock | input | 1 | Downstream lock level |
| ev_hotplug | input | 1 | Downstream hot-plug event |
| rx_present | input | 1 | Receiver detected level |
| ev_list_ready | input | 1 | Key list ready event |
| ev_key_ready | input | 1 | Receiver key ready event |
| ev_auth_pass | input | 1 | Authentication succeeded |
| ev_auth_fail | input | 1 | Authentication failed or lost |
| ev_auth_restart | input | 1 | Host restarted authentication |
| ev_ind_done | input | 1 | Indirect register access complete |
| wr_list_valid | input | 1 | Host write of the list-valid control bit |
| wr_key_valid | input | 1 | Host write of the key-valid control bit |
| rxdet_sel | input | 1 | Hold receiver-detect interrupt until lock |
| irq | output | 1 | Interrupt to host controller |

## Verification
The bench drives set events and the clearing actions that match them in the same cycle. A design that lets the clear win would silently lose a channel error or a key-ready notice. The bench also reads the status register while the interrupt line is high from a pass event, and expects the line to drop. A design that clears pass/fail flags on other reads, or never clears them, would leave the interrupt stuck or drop it too early. Receiver detect is exercised with `rxdet_sel` high and `ds_lock` both low and high, which catches a gate that is ignored or inverted. Writes to the read-only address and reads of unmapped addresses while flags are pending expose decoders that alias addresses or clear on any read.

// File: rtl/lnk_auth_irq.sv
module lnk_auth_irq #(
  parameter logic [7:0] STAT_ADDR = 8'hC4,
  parameter logic [7:0] CTRL_ADDR = 8'hC6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ev_chan_err,
  input  logic       dsirq_n,
  input  logic       ds_lock,
  input  logic       ev_hotplug,
  input  logic       rx_present,
  input  logic       ev_list_ready,
  input  logic       ev_key_ready,
  input  logic       ev_auth_pass,
  input  logic       ev_auth_fail,
  input  logic       ev_auth_restart,
  input  logic       ev_ind_done,
  input  logic       wr_list_valid,
  input  logic       wr_key_valid,
  input  logic       rxdet_sel,
  output logic       irq
);

  logic       err_q, hp_q, list_q, key_q, auth_q;
  logic       pass_q, fail_q, ind_q;
  logic [7:0] ctl_q;

  wire stat_rd = reg_rd && (reg_addr == STAT_ADDR);
  wire ctl_wr  = reg_wr && (reg_addr == CTRL_ADDR);

  wire [7:0] stat = {err_q, dsirq_n, ds_lock, hp_q, rx_present, list_q, key_q, auth_q};

  wire       rxdet_pend = rx_present && (!rxdet_sel || ds_lock);
  wire [7:1] pend = {ind_q, rxdet_pend, !dsirq_n, list_q, key_q, fail_q, pass_q};

  assign irq = ctl_q[0] && |(ctl_q[7:1] & pend);

  assign reg_rdata = (reg_addr == STAT_ADDR) ? stat :
                     (reg_addr == CTRL_ADDR) ? ctl_q : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      hp_q   <= 1'b0;
      list_q <= 1'b0;
      key_q  <= 1'b0;
      auth_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      ind_q  <= 1'b0;
      ctl_q  <= 8'h00;
    end else begin
      err_q  <= ev_chan_err   | (err_q  & !stat_rd);
      hp_q   <= ev_hotplug    | (hp_q   & !stat_rd);
      pass_q <= ev_auth_pass  | (pass_q & !stat_rd);
      fail_q <= ev_auth_fail  | (fail_q & !stat_rd);
      ind_q  <= ev_ind_done   | (ind_q  & !stat_rd);
      list_q <= ev_list_ready | (list_q & !wr_list_valid);
      key_q  <= ev_key_ready  | (key_q  & !wr_key_valid);
      auth_q <= ev_auth_pass  | (auth_q & !ev_auth_fail & !ev_auth_restart);
      if (ctl_wr) ctl_q <= reg_wdata;
    end
  end

  p_cor_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_chan_err) |=> !err_q);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chan_err && stat_rd) |=> err_q);
  p_key_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q && !wr_key_valid) |=> key_q);
  p_auth_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_auth_pass |=> auth_q);
  p_ctl_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q == $past(reg_wdata)));
  p_global_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> !irq);
  p_rxdet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == 8'h41 && rxdet_sel && !ds_lock) |-> !irq);
  p_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_ADDR) |=> $stable(ctl_q));

endmodule

// File: tb/lnk_auth_irq_tb.sv
module lnk_auth_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = 8'hC4, reg_wdata = 8'h00;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_rdata;
  logic ev_chan_err = 0, dsirq_n = 0, ds_lock = 0, ev_hotplug = 0, rx_present = 0;
  logic ev_list_ready = 0, ev_key_ready = 0, ev_auth_pass = 0, ev_auth_fail = 0;
  logic ev_auth_restart = 0, ev_ind_done = 0, wr_list_valid = 0, wr_key_valid = 0;
  logic rxdet_sel = 0;
  logic irq;

  int total = 0, fails = 0;
  bit done = 0;
  int m_err, m_hp, m_list, m_key, m_auth, m_pass, m_fail, m_ind, m_ctl;

  always #10 clk = ~clk;

  lnk_auth_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_chan_err(ev_chan_err),
    .dsirq_n(dsirq_n), .ds_lock(ds_lock), .ev_hotplug(ev_hotplug), .rx_present(rx_present),
    .ev_list_ready(ev_list_ready), .ev_key_ready(ev_key_ready), .ev_auth_pass(ev_auth_pass),
    .ev_auth_fail(ev_auth_fail), .ev_auth_restart(ev_auth_restart), .ev_ind_done(ev_ind_done),
    .wr_list_valid(wr_list_valid), .wr_key_valid(wr_key_valid), .rxdet_sel(rxdet_sel),
    .irq(irq));

  task automatic step(input string tag);
    int stat, exp_rd, exp_irq, rxp, any, st_rd;
    #1;
    stat = (m_err << 7) | (int'(dsirq_n) << 6) | (int'(ds_lock) << 5) | (m_hp << 4) |
           (int'(rx_present) << 3) | (m_list << 2) | (m_key << 1) | m_auth;
    if (reg_addr == 8'hC4) exp_rd = stat;
    else if (reg_addr == 8'hC6) exp_rd = m_ctl;
    else exp_rd = 0;
    rxp = (rx_present && (!rxdet_sel || ds_lock)) ? 1 : 0;
    any = 0;
    if (m_ctl[7] && m_ind) any = 1;
    if (m_ctl[6] && rxp) any = 1;
    if (m_ctl[5] && !dsirq_n) any = 1;
    if (m_ctl[4] && m_list) any = 1;
    if (m_ctl[3] && m_key) any = 1;
    if (m_ctl[2] && m_fail) any = 1;
    if (m_ctl[1] && m_pass) any = 1;
    exp_irq = (m_ctl[0] && any) ? 1 : 0;
    total++;
    if (int'(reg_rdata) != exp_rd || int'(irq) != exp_irq) begin
      fails++;
      $display("FAIL %s: rdata=%02h irq=%0d expected rdata=%02h irq=%0d",
               tag, reg_rdata, irq, exp_rd, exp_irq);
    end
    if (!rst_n) begin
      m_err = 0; m_hp = 0; m_list = 0; m_key = 0; m_auth = 0;
      m_pass = 0; m_fail = 0; m_ind = 0; m_ctl = 0;
    end else begin
      st_rd = (reg_rd && reg_addr == 8'hC4) ? 1 : 0;
      if (ev_chan_err) m_err = 1; else if (st_rd) m_err = 0;
      if (ev_hotplug) m_hp = 1; else if (st_rd) m_hp = 0;
      if (ev_auth_pass) m_pass = 1; else if (st_rd) m_pass = 0;
      if (ev_auth_fail) m_fail = 1; else if (st_rd) m_fail = 0;
      if (ev_ind_done) m_ind = 1; else if (st_rd) m_ind = 0;
      if (ev_list_ready) m_list = 1; else if (wr_list_valid) m_list = 0;
      if (ev_key_ready) m_key = 1; else if (wr_key_valid) m_key = 0;
      if (ev_auth_pass) m_auth = 1; else if (ev_auth_fail || ev_auth_restart) m_auth = 0;
      if (reg_wr && reg_addr == 8'hC6) m_ctl = int'(reg_wdata);
    end
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0; ev_chan_err = 0; ev_hotplug = 0; ev_list_ready = 0;
    ev_key_ready = 0; ev_auth_pass = 0; ev_auth_fail = 0; ev_auth_restart = 0;
    ev_ind_done = 0; wr_list_valid = 0; wr_key_valid = 0;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v, input string tag);
    reg_addr = 8'hC6; reg_wdata = v; reg_wr = 1; step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    ev_chan_err = 1; step("R1");            // event during reset must be discarded
    step("R1");
    rst_n = 1;
    reg_addr = 8'hC4; step("R1");
    reg_addr = 8'hC6; step("R1");

    wr_ctl(8'hA5, "R7"); step("R7");
    wr_ctl(8'h5A, "R7"); step("R7");

    reg_addr = 8'hC4;
    dsirq_n = 1; step("R2");
    ds_lock = 1; step("R2");
    rx_present = 1; step("R2");
    dsirq_n = 0; ds_lock = 0; rx_present = 0; step("R2");
    dsirq_n = 1;

    wr_ctl(8'h00, "R3"); reg_addr = 8'hC4;
    ev_chan_err = 1; step("R3");
    step("R3"); step("R3");
    reg_rd = 1; step("R3");
    step("R3");
    ev_hotplug = 1; step("R3");
    reg_rd = 1; step("R3");
    step("R3");

    ev_chan_err = 1; reg_rd = 1; step("R4");
    step("R4");
    ev_hotplug = 1; reg_rd = 1; step("R4");
    step("R4");
    reg_rd = 1; step("R4");
    step("R4");

    ev_key_ready = 1; step("R5");
    reg_rd = 1; step("R5");
    step("R5");
    wr_key_valid = 1; step("R5");
    step("R5");
    ev_list_ready = 1; step("R5");
    wr_key_valid = 1; step("R5");
    wr_list_valid = 1; ev_list_ready = 1; step("R5");
    step("R5");
    wr_list_valid = 1; step("R5");
    step("R5");

    ev_auth_pass = 1; step("R6");
    step("R6");
    ev_auth_fail = 1; step("R6");
    step("R6");
    ev_auth_pass = 1; step("R6");
    ev_auth_restart = 1; step("R6");
    step("R6");
    reg_rd = 1; step("R6");

    wr_ctl(8'h03, "R8"); reg_addr = 8'hC4;
    ev_auth_pass = 1; step("R8");
    step("R8");
    reg_addr = 8'hC6; reg_rd = 1; step("R8");
    reg_addr = 8'hC4; reg_rd = 1; step("R8");
    step("R8");
    wr_ctl(8'h02, "R8"); reg_addr = 8'hC4;
    ev_auth_pass = 1; step("R8");
    step("R8");
    wr_ctl(8'h05, "R8"); reg_addr = 8'hC4;
    ev_auth_fail = 1; step("R8");
    step("R8");
    reg_rd = 1; step("R8");
    wr_ctl(8'h81, "R8"); reg_addr = 8'hC4;
    ev_ind_done = 1; step("R8");
    reg_rd = 1; step("R8");
    step("R8");
    wr_ctl(8'h21, "R8"); reg_addr = 8'hC4;
    dsirq_n = 0; step("R8");
    dsirq_n = 1; step("R8");
    wr_ctl(8'h19, "R8"); reg_addr = 8'hC4;
    ev_key_ready = 1; step("R8");
    wr_key_valid = 1; step("R8");
    step("R8");

    wr_ctl(8'h41, "R9"); reg_addr = 8'hC4;
    rxdet_sel = 1; rx_present = 1; ds_lock = 0; step("R9");
    step("R9");
    ds_lock = 1; step("R9");
    rxdet_sel = 0; ds_lock = 0; step("R9");
    rx_present = 0; step("R9");

    reg_addr = 8'hC6; step("R10");
    reg_addr = 8'hC4; reg_wdata = 8'hFF; reg_wr = 1; step("R10");
    reg_addr = 8'hC6; step("R10");
    reg_addr = 8'hC4; step("R10");
    ev_chan_err = 1; step("R10");
    reg_addr = 8'h10; reg_rd = 1; step("R10");
    reg_addr = 8'hC5; reg_rd = 1; step("R10");
    reg_addr = 8'hC4; step("R10");
    reg_addr = 8'hC7; reg_wdata = 8'h00; reg_wr = 1; step("R10");
    reg_addr = 8'hC6; step("R10");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule